// File: doc/BRIEF.md
# Folded Single-Port Word Memory

This block stores 2^ADDR_W words of DATA_W bits in a physically folded array. Each physical row is 2^COL_SEL_W words wide. An incoming word address is split in two. The high bits pick one physical row through a predecoded one-hot word-line decoder. The low bits drive one tree multiplexer per data bit, and that multiplexer picks the addressed word out of the wide row. In the wide row, the storage for data bit b of every word sits in a contiguous block of 2^COL_SEL_W columns. Column c of that block holds word c.

Requests enter through a valid/ready port. The port accepts one access per cycle, either a read or a write. A read returns its data on a valid/ready response port in the cycle after the read is accepted. A write returns nothing. Back-pressure is simple: when a response is waiting and the consumer is not ready, `req_ready` drops. The waiting response is then held unchanged until `rsp_ready` is seen high.

Top module: `folded_sram`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A read accepted at a clock edge (`req_valid`=1, `req_ready`=1, `req_we`=0) makes `rsp_valid` 1 after that edge. `rsp_rdata` then holds the word most recently written to that address.
- R3: A write (`req_we`=1) changes only the addressed word. The other words sharing the same physical row keep their values.
- R4: Address bits [COL_SEL_W-1:0] select the word within a row, and the remaining high bits select the row. All 2^ADDR_W addresses hold independent words, including address 0 and the top address.
- R5: For every address, exactly one word line is active.
- R6: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0, no request is accepted, and `rsp_valid` and `rsp_rdata` stay unchanged.
- R7: An accepted write never produces a response. After a write is accepted with no response pending, `rsp_valid` is 0.
- R8: When `rsp_valid`=1 and `rsp_ready`=1 at an edge, the response is consumed. A read accepted at that same edge returns its own data in the next cycle, so reads can be issued back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address (low COL_SEL_W bits = column, rest = row) |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | DATA_W | Read data |

## Verification
The hardest case to reach from the ports is the stalled response. It needs a second read waiting on the request port while the first result is held. The release edge must then consume the old response and accept the new read at the same moment. The bench holds `rsp_ready` low across several cycles with a second read asserted. It then raises `rsp_ready` and checks that the next cycle shows the second word. Column isolation is exercised by filling one row column by column, then rewriting a single column and reading back its neighbours.

// File: rtl/folded_sram_pkg.sv
package folded_sram_pkg;
  // number of 2-bit predecode groups needed for a row address of width w
  function automatic int unsigned predec_groups(input int unsigned w);
    return (w + 1) / 2;
  endfunction
endpackage

// File: rtl/fs_row_predec.sv
module fs_row_predec #(
  parameter int unsigned ROW_W = 8
) (
  input  logic [ROW_W-1:0]        row_addr,
  output logic [(1<<ROW_W)-1:0]   word_line
);
  import folded_sram_pkg::*;
  localparam int unsigned ROWS  = 1 << ROW_W;
  localparam int unsigned NGRP  = predec_groups(ROW_W);
  localparam int unsigned PAD_W = 2 * NGRP;

  logic [PAD_W-1:0] a_pad;
  logic [3:0]       pre [NGRP];

  assign a_pad = PAD_W'(row_addr);

  // each address pair becomes a 1-of-4 hot line set
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar v = 0; v < 4; v++) begin : g_line
      assign pre[g][v] = (a_pad[2*g +: 2] == 2'(v));
    end
  end

  // each word line ANDs one line from every group
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [NGRP-1:0] terms;
    for (genvar g = 0; g < NGRP; g++) begin : g_term
      localparam int unsigned SEL = (r >> (2 * g)) & 3;
      assign terms[g] = pre[g][SEL];
    end
    assign word_line[r] = &terms;
  end
endmodule

// File: rtl/fs_col_mux.sv
module fs_col_mux #(
  parameter int unsigned SEL_W = 3
) (
  input  logic [(1<<SEL_W)-1:0] cols,
  input  logic [SEL_W-1:0]      sel,
  output logic                  bit_out
);
  localparam int unsigned N = 1 << SEL_W;

  logic [N-1:0] lvl [SEL_W+1];
  assign lvl[0] = cols;

  // one select level per column-address bit, LSB first
  for (genvar l = 0; l < SEL_W; l++) begin : g_lvl
    localparam int unsigned OUTS = N >> (l + 1);
    for (genvar i = 0; i < N; i++) begin : g_node
      if (i < OUTS) begin : g_pick
        assign lvl[l+1][i] = sel[l] ? lvl[l][2*i+1] : lvl[l][2*i];
      end else begin : g_zero
        assign lvl[l+1][i] = 1'b0;
      end
    end
  end

  assign bit_out = lvl[SEL_W][0];
endmodule

// File: rtl/folded_sram.sv
module folded_sram #(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned COL_SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int unsigned ROW_W  = ADDR_W - COL_SEL_W;
  localparam int unsigned ROWS   = 1 << ROW_W;
  localparam int unsigned COLS   = 1 << COL_SEL_W;
  localparam int unsigned ROW_BW = DATA_W * COLS;

  logic [ROW_W-1:0]     row_a;
  logic [COL_SEL_W-1:0] col_a;
  logic [ROWS-1:0]      wl;
  logic [ROW_BW-1:0]    mem [ROWS];
  logic [ROW_BW-1:0]    rd_row, wr_wide, wr_mask;
  logic [COLS-1:0]      col_hot;
  logic [DATA_W-1:0]    mux_word;
  logic                 acc, wr_fire, rd_fire;

  assign col_a = req_addr[COL_SEL_W-1:0];
  assign row_a = req_addr[ADDR_W-1:COL_SEL_W];

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_fire   = acc && req_we;
  assign rd_fire   = acc && !req_we;

  fs_row_predec #(.ROW_W(ROW_W)) u_rowdec (
    .row_addr (row_a),
    .word_line(wl)
  );

  assign col_hot = COLS'(1) << col_a;

  // bit b of every word sits in columns [b*COLS +: COLS]
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign wr_wide[b*COLS +: COLS] = {COLS{req_wdata[b]}};
    assign wr_mask[b*COLS +: COLS] = col_hot;
    fs_col_mux #(.SEL_W(COL_SEL_W)) u_cmux (
      .cols   (rd_row[b*COLS +: COLS]),
      .sel    (col_a),
      .bit_out(mux_word[b])
    );
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (wr_fire && wl[r])
        mem[r] <= (mem[r] & ~wr_mask) | (wr_wide & wr_mask);
    end
  end

  // word-line gated row read (one-hot AND-OR)
  always_comb begin
    rd_row = '0;
    for (int r = 0; r < ROWS; r++)
      rd_row = rd_row | (mem[r] & {ROW_BW{wl[r]}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= mux_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R5: a single word line per access
  p_one_wordline_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones(wl) == 1);

  // R6: stalled response is held and intake is closed
  p_hold_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_stall_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R2: read result follows one cycle after acceptance
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_we) |=> rsp_valid);

  // R7: writes give no response
  p_write_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_we) |=> !rsp_valid);
endmodule

// File: tb/tb_folded_sram.sv
module tb_folded_sram;
  localparam int AW = 11;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;

  int total = 0, bad = 0;
  logic [DW-1:0] model [1<<AW];

  always #2 clk = ~clk;

  folded_sram dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    model[a] = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check({req, " data"}, 32'(rsp_rdata), 32'(model[a]));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 req_ready", 32'(req_ready), 1);
  endtask

  task automatic t_basic;
    wr(11'h123, 16'hBEEF);
    rd("R2", 11'h123);
    wr(11'h000, 16'h1111);
    wr(11'h7FF, 16'hFFFE);
    rd("R4 addr0", 11'h000);
    rd("R4 top", 11'h7FF);
  endtask

  task automatic t_columns;
    for (int c = 0; c < 8; c++) wr(11'(5*8 + c), 16'(16'hA000 + c*16'h0111));
    wr(11'(5*8 + 3), 16'h5A5A);
    for (int c = 0; c < 8; c++) rd("R3", 11'(5*8 + c));
  endtask

  task automatic t_rows;
    for (int r = 0; r < 256; r++) wr(11'(r*8 + 6), 16'(r * 16'h0101 ^ 16'h3C3C));
    for (int r = 0; r < 256; r++) rd("R4 R5 rows", 11'(r*8 + 6));
  endtask

  task automatic t_write_silent;
    wr(11'h055, 16'h0F0F);
    @(negedge clk);
    check("R7 no rsp after write", 32'(rsp_valid), 0);
  endtask

  task automatic t_backpressure;
    wr(11'h200, 16'hCAFE);
    wr(11'h201, 16'hD00D);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_we = 1'b0; req_addr = 11'h200;
    @(posedge clk);
    @(negedge clk);
    req_addr = 11'h201;
    for (int i = 0; i < 3; i++) begin
      check("R6 held valid", 32'(rsp_valid), 1);
      check("R6 held data", 32'(rsp_rdata), 32'h0000CAFE);
      check("R6 ready low", 32'(req_ready), 0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 next valid", 32'(rsp_valid), 1);
    check("R8 next data", 32'(rsp_rdata), 32'h0000D00D);
    @(negedge clk);
    check("R8 drained", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_basic();
    t_columns();
    t_rows();
    t_write_silent();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule